// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block sits between a processor register port and a raw 8-bit NAND flash bus. Software controls the command-latch, address-latch and chip-enable pins through a mode register. Every access to the data register becomes one timed bus cycle on the flash pins: a write drives a byte and pulses the write strobe, and a read pulses the read strobe and captures the byte the flash returns. The flash command protocol is left to software. So is error correction, which belongs to another block.

The strobe cycle is set by a timing register. The pulse is held low for one clock more than its programmed width, and then a programmed number of hold clocks follows before the next data access may start. Data writes are posted: they are accepted at once if the bus is free. A data read holds off the register handshake until the captured byte is ready. A data access that arrives while a strobe cycle is still running is stalled until that cycle ends. A status register reports whether the flash is busy and whether a strobe cycle is in progress. A self-clearing reset bit returns the controller to its idle state.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After `rst_n` is released, every `ce_n` line, `we_n` and `re_n` are 1, `cle`, `ale` and `io_oe` are 0, and the mode, timing, status and reset registers all read 0.
- R2: In the mode register at offset 0x04, bit 0 drives `cle` and bit 1 drives `ale`. Reading it back returns only the defined bits 7, 4, 3:2, 1 and 0, so a write of 0xFF reads back as 0x9F.
- R3: Mode bit 4 is the chip-enable request and mode bits 3:2 pick one of the `ce_n` lines. Only the picked line goes low, and only while bit 4 is 1. All other lines stay high.
- R4: The timing register at offset 0x14 holds the hold count in bits 7:4 and the strobe-width count in bits 3:0, and reads back as written.
- R5: A data access drives its strobe (`we_n` for a write, `re_n` for a read) low for exactly width+1 clocks. The two strobes are never low together, and hold clocks follow the strobe before the bus is free.
- R6: A write to the data register at offset 0x00 drives only bits 7:0 of `wdata` onto `io_out`. If no cycle is running, the write is accepted in the same cycle, and `io_out` stays steady through the strobe.
- R7: A read of the data register captures `io_in` at the clock edge where `re_n` rises. It completes after the hold clocks and returns the byte in bits 7:0 with all upper bits 0. With hold 0, `ready` comes width+2 clocks after the request.
- R8: A data access made while a strobe cycle or its hold is running sees `ready` low until the cycle has fully finished.
- R9: Status register (offset 0x08) bit 6 reads 1 while a strobe cycle, its hold or a soft reset is in progress, and 0 otherwise.
- R10: Status bit 7 reads 1 while `rb_n` is low, as seen through a two-stage synchronizer.
- R11: Writing 1 to bit 0 of the reset register at offset 0x18 clears mode, timing, data and any running cycle. The bit reads 1 for RST_CYCLES clocks, and then clears itself.
- R12: Mode bit 7 drives `io_oe`.
- R13: The offsets that are not mapped (including 0x0C and 0x10) read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access request, held until ready |
| we | input | 1 | 1 for a register write, 0 for a read |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while ready is high |
| ready | output | 1 | Access completes at the next rising edge |
| ce_n | output | N_CE | Active-low flash chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| io_out | output | BUS_W | Byte driven toward the flash |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | BUS_W | Byte returned by the flash |
| rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions assume a requester that keeps `req`, `we`, `addr` and `wdata` steady until it sees `ready`. They also assume that the mode byte never makes more than one enable line active, which the decoder guarantees. The bench keeps to this rule: every access goes through one task that drives the inputs at the falling edge and drops `req` only after the accepting edge. It changes `io_in` only after the capture edge of a read and moves `rb_n` only between accesses. It mixes posted writes with accesses that run back to back into a busy cycle, changes the timing values, and runs a soft reset.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    // Register offsets; positions the software map depends on.
    localparam int OFF_DATA = 'h00;
    localparam int OFF_MODE = 'h04;
    localparam int OFF_STAT = 'h08;
    localparam int OFF_TIME = 'h14;
    localparam int OFF_RST  = 'h18;

    // Bit positions inside the mode byte.
    localparam int MB_CLE = 0;
    localparam int MB_ALE = 1;
    localparam int MB_SEL = 2;
    localparam int MB_CE  = 4;
    localparam int MB_OE  = 7;

    // Bit positions inside the status byte.
    localparam int SB_CTL_BUSY   = 6;
    localparam int SB_FLASH_BUSY = 7;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_HOLD   = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;

endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = (sh_q << 1) | STAGES'(d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/nfc_ce_decode.sv
module nfc_ce_decode #(
    parameter int N_CE  = 4,
    parameter int SEL_W = 2
) (
    input  logic             ce,
    input  logic [SEL_W-1:0] sel,
    output logic [N_CE-1:0]  ce_n
);

    for (genvar i = 0; i < N_CE; i++) begin : g_line
        assign ce_n[i] = !(ce && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/nfc_strobe_engine.sv
module nfc_strobe_engine
    import nfc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start_wr,
    input  logic             start_rd,
    input  logic [CNT_W-1:0] spw,
    input  logic [CNT_W-1:0] hold,
    input  logic [BUS_W-1:0] io_in,
    output logic             idle,
    output logic             done,
    output logic             wr_strobe,
    output logic             rd_strobe,
    output logic [BUS_W-1:0] rd_byte
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             rd;
        logic [BUS_W-1:0] rbyte;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (start_wr || start_rd) begin
                    d.ph  = PH_STROBE;
                    d.cnt = spw;
                    d.rd  = start_rd;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    if (q.rd) d.rbyte = io_in;
                    if (hold == '0) begin
                        d.ph = q.rd ? PH_DONE : PH_IDLE;
                    end else begin
                        d.ph  = PH_HOLD;
                        d.cnt = hold - CNT_W'(1);
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) d.ph = q.rd ? PH_DONE : PH_IDLE;
                else             d.cnt = q.cnt - CNT_W'(1);
            end
            default: d.ph = PH_IDLE;
        endcase
        if (clear) begin
            d.ph    = PH_IDLE;
            d.cnt   = '0;
            d.rd    = 1'b0;
            d.rbyte = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, cnt: '0, rd: 1'b0, rbyte: '0};
        else        q <= d;
    end

    assign idle      = (q.ph == PH_IDLE);
    assign done      = (q.ph == PH_DONE);
    assign wr_strobe = (q.ph == PH_STROBE) && !q.rd;
    assign rd_strobe = (q.ph == PH_STROBE) &&  q.rd;
    assign rd_byte   = q.rbyte;

endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
    import nfc_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int BUS_W       = 8,
    parameter int N_CE        = 4,   // 2..4: select field is bits 3:2
    parameter int CNT_W       = 4,   // up to 4: fields share one byte
    parameter int RST_CYCLES  = 4,   // at least 1
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic [N_CE-1:0]   ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [BUS_W-1:0]  io_out,
    output logic              io_oe,
    input  logic [BUS_W-1:0]  io_in,
    input  logic              rb_n
);

    localparam int SEL_W = (N_CE > 1) ? $clog2(N_CE) : 1;
    localparam int RST_W = $clog2(RST_CYCLES + 1);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFF_TIME);
    localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RST);

    typedef struct packed {
        logic             oe;
        logic             ce;
        logic [SEL_W-1:0] sel;
        logic             ale;
        logic             cle;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] spw;
        logic [BUS_W-1:0] dat;
        logic [RST_W-1:0] srst;
    } regs_t;

    regs_t q, n;

    logic             is_data, srst_busy, trig, wr_acc;
    logic             start_wr, start_rd, eng_clear;
    logic             eng_idle, eng_done, wr_strobe, rd_strobe;
    logic [BUS_W-1:0] eng_rbyte;
    logic             rb_sync_n;
    logic [7:0]       rd8;
    logic             wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:8];

    // ---------------- handshake ----------------
    always_comb begin
        is_data   = (addr == A_DATA);
        srst_busy = (q.srst != '0);
        start_wr  = req && is_data &&  we && eng_idle && !srst_busy;
        start_rd  = req && is_data && !we && eng_idle && !srst_busy;
        ready     = req && (!is_data || start_wr || eng_done);
        wr_acc    = req && we && ready;
        trig      = wr_acc && (addr == A_RST) && wdata[0] && !srst_busy;
        eng_clear = srst_busy || trig;
    end

    // ---------------- register next state ----------------
    always_comb begin
        n = q;
        if (srst_busy) begin
            n      = '0;
            n.srst = q.srst - RST_W'(1);
        end else if (trig) begin
            n      = '0;
            n.srst = RST_W'(RST_CYCLES);
        end else begin
            if (wr_acc && addr == A_MODE) begin
                n.oe  = wdata[MB_OE];
                n.ce  = wdata[MB_CE];
                n.sel = wdata[MB_SEL +: SEL_W];
                n.ale = wdata[MB_ALE];
                n.cle = wdata[MB_CLE];
            end
            if (wr_acc && addr == A_TIME) begin
                n.hold = wdata[4 +: CNT_W];
                n.spw  = wdata[0 +: CNT_W];
            end
            if (start_wr) n.dat = wdata[BUS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd8 = '0;
        case (addr)
            A_DATA: rd8 = 8'(eng_rbyte);
            A_MODE: begin
                rd8[MB_OE]             = q.oe;
                rd8[MB_CE]             = q.ce;
                rd8[MB_SEL +: SEL_W]   = q.sel;
                rd8[MB_ALE]            = q.ale;
                rd8[MB_CLE]            = q.cle;
            end
            A_STAT: begin
                rd8[SB_FLASH_BUSY] = !rb_sync_n;
                rd8[SB_CTL_BUSY]   = !eng_idle || srst_busy;
            end
            A_TIME: begin
                rd8[4 +: CNT_W] = q.hold;
                rd8[0 +: CNT_W] = q.spw;
            end
            A_RST:   rd8[0] = srst_busy;
            default: rd8 = '0;
        endcase
        rdata = DATA_W'(rd8);
    end

    // ---------------- sub-blocks ----------------
    nfc_strobe_engine #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (eng_clear),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .spw       (q.spw),
        .hold      (q.hold),
        .io_in     (io_in),
        .idle      (eng_idle),
        .done      (eng_done),
        .wr_strobe (wr_strobe),
        .rd_strobe (rd_strobe),
        .rd_byte   (eng_rbyte)
    );

    nfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rb_n),
        .q     (rb_sync_n)
    );

    nfc_ce_decode #(.N_CE(N_CE), .SEL_W(SEL_W)) i_ce (
        .ce   (q.ce),
        .sel  (q.sel),
        .ce_n (ce_n)
    );

    assign cle    = q.cle;
    assign ale    = q.ale;
    assign io_oe  = q.oe;
    assign io_out = q.dat;
    assign we_n   = !wr_strobe;
    assign re_n   = !rd_strobe;

endmodule

// File: rtl/nand_bus_ctrl_chk.sv
module nand_bus_ctrl_chk
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int N_CE   = 4,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic              ready,
    input logic [N_CE-1:0]   ce_n,
    input logic              we_n,
    input logic              re_n,
    input logic [BUS_W-1:0]  io_out,
    input logic              srst_busy
);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    p_ce_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !(req && ready && addr == ADDR_W'(OFF_DATA)));

    p_io_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(io_out));

    p_srst_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (&ce_n && we_n && re_n));

endmodule

bind nand_bus_ctrl nand_bus_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .N_CE   (N_CE),
    .BUS_W  (BUS_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .addr      (addr),
    .ready     (ready),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .re_n      (re_n),
    .io_out    (io_out),
    .srst_busy (srst_busy)
);

// File: tb/test_nand_bus_ctrl.sv
`timescale 1ns/1ps
module test_nand_bus_ctrl;

    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;
    logic [3:0]  ce_n;
    logic        cle, ale, we_n, re_n, io_oe;
    logic [7:0]  io_out;
    logic [7:0]  io_in = 8'h00;
    logic        rb_n = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nand_bus_ctrl #(.RST_CYCLES(RSTC)) i_nand_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .ce_n(ce_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_ph, m_sl, m_hl, m_srst;
    bit         m_rd;
    logic [7:0] m_mode, m_tim, m_dat, m_rb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_sl = 0; m_hl = 0; m_srst = 0; m_rd = 0;
            m_mode = 0; m_tim = 0; m_dat = 0; m_rb = 0;
        end else if (m_srst > 0) begin
            m_srst--;
            m_mode = 0; m_tim = 0; m_dat = 0; m_rb = 0; m_ph = 0; m_rd = 0;
        end else if (req && we && addr == 5'h18 && wdata[0]) begin
            m_srst = RSTC;
            m_mode = 0; m_tim = 0; m_dat = 0; m_rb = 0; m_ph = 0; m_rd = 0;
        end else begin
            case (m_ph)
                0: if (req && addr == 5'h00) begin
                       m_ph = 1; m_sl = m_tim[3:0] + 1; m_rd = !we;
                       if (we) m_dat = wdata[7:0];
                   end
                1: begin
                       m_sl--;
                       if (m_sl == 0) begin
                           if (m_rd) m_rb = io_in;
                           if (m_tim[7:4] == 0) m_ph = m_rd ? 3 : 0;
                           else begin m_ph = 2; m_hl = m_tim[7:4]; end
                       end
                   end
                2: begin
                       m_hl--;
                       if (m_hl == 0) m_ph = m_rd ? 3 : 0;
                   end
                default: m_ph = 0;
            endcase
            if (req && we && addr == 5'h04) m_mode = wdata[7:0] & 8'h9F;
            if (req && we && addr == 5'h14) m_tim = wdata[7:0];
        end
    end

    // compare pins every clock, ready a little later once inputs settle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [3:0] exp_ce;
            bit         exp_rdy;
            for (int i = 0; i < 4; i++)
                exp_ce[i] = !(m_mode[4] && m_mode[3:2] == i[1:0]);
            chk(we_n == !(m_ph == 1 && !m_rd), "R5", "we_n", we_n, !(m_ph == 1 && !m_rd));
            chk(re_n == !(m_ph == 1 &&  m_rd), "R5", "re_n", re_n, !(m_ph == 1 && m_rd));
            chk(ce_n == exp_ce, "R3", "ce_n", ce_n, exp_ce);
            chk(cle == m_mode[0] && ale == m_mode[1], "R2", "cle/ale",
                {cle, ale}, {m_mode[0], m_mode[1]});
            chk(io_oe == m_mode[7], "R12", "io_oe", io_oe, m_mode[7]);
            chk(io_out == m_dat, "R6", "io_out", io_out, m_dat);
            #1;
            exp_rdy = req && (addr != 5'h00 || (m_ph == 0 && we && m_srst == 0) || m_ph == 3);
            chk(ready == exp_rdy, "R8", "ready", ready, exp_rdy);
        end
    end

    // ---------------- bus access ----------------
    task automatic access(input bit w, input logic [4:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waits);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; waits = 0;
        forever begin
            #1;
            if (ready) begin rd = rdata; break; end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] r; int w;
        access(1'b1, a, d, r, w);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string rq);
        logic [31:0] r; int w;
        access(1'b0, a, 32'h0, r, w);
        chk(r == exp, rq, $sformatf("read @%0h", a), r, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] r;
        int w, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle pins and cleared registers
        chk(ce_n == 4'hF && we_n && re_n && !cle && !ale && !io_oe, "R1", "pins",
            {ce_n, we_n, re_n, cle, ale, io_oe}, 9'h1F8);
        rd_chk(5'h04, 32'h0, "R1");
        rd_chk(5'h08, 32'h0, "R1");
        rd_chk(5'h14, 32'h0, "R1");
        rd_chk(5'h18, 32'h0, "R1");

        // R2 / R3: latch pins and enable decoding
        wr(5'h04, 32'h13);
        chk(cle && ale, "R2", "cle&ale", {cle, ale}, 2'b11);
        chk(ce_n == 4'b1110, "R3", "ce_n sel0", ce_n, 4'b1110);
        wr(5'h04, 32'h18);
        chk(ce_n == 4'b1011 && !cle, "R3", "ce_n sel2", ce_n, 4'b1011);
        wr(5'h04, 32'h08);
        chk(ce_n == 4'b1111, "R3", "ce off", ce_n, 4'b1111);
        wr(5'h04, 32'hFF);
        rd_chk(5'h04, 32'h9F, "R2");

        // R4: timing register
        wr(5'h14, 32'h31);
        rd_chk(5'h14, 32'h31, "R4");

        // R12 / R6 / R5 / R9: posted write, strobe width, busy flag
        wr(5'h04, 32'h90);
        chk(io_oe == 1'b1, "R12", "io_oe on", io_oe, 1);
        access(1'b1, 5'h00, 32'h005A_5AC3, r, w);
        chk(w == 0, "R6", "posted write waits", w, 0);
        chk(io_out == 8'hC3, "R6", "low byte only", io_out, 8'hC3);
        cnt = 0;
        while (we_n == 1'b0) begin cnt++; @(negedge clk); end
        chk(cnt == 2, "R5", "we_n low clocks", cnt, 2);
        rd_chk(5'h08, 32'h40, "R9");
        repeat (4) @(negedge clk);
        rd_chk(5'h08, 32'h00, "R9");

        // R8: second data write during a running cycle is stalled
        wr(5'h14, 32'h23);
        access(1'b1, 5'h00, 32'h11, r, w);
        access(1'b1, 5'h00, 32'h22, r, w);
        chk(w == 5, "R8", "stall clocks", w, 5);
        chk(io_out == 8'h22, "R6", "second byte", io_out, 8'h22);
        repeat (8) @(negedge clk);

        // R7: read capture at the rising read strobe, upper bits zero
        io_in = 8'hA7;
        fork
            access(1'b0, 5'h00, 32'h0, r, w);
            begin
                wait (re_n == 1'b0);
                wait (re_n == 1'b1);
                io_in = 8'h3C;
            end
        join
        chk(r == 32'h0000_00A7, "R7", "read byte", r, 32'hA7);
        wr(5'h14, 32'h02);
        io_in = 8'h61;
        access(1'b0, 5'h00, 32'h0, r, w);
        chk(r == 32'h61, "R7", "read hold0", r, 32'h61);
        chk(w == 4, "R7", "read latency hold0", w, 4);

        // R10: flash busy through synchronizer
        rb_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk(5'h08, 32'h80, "R10");
        rb_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(5'h08, 32'h00, "R10");

        // R13: unmapped offsets
        wr(5'h0C, 32'hFF);
        wr(5'h10, 32'hFF);
        rd_chk(5'h0C, 32'h0, "R13");
        rd_chk(5'h10, 32'h0, "R13");
        rd_chk(5'h04, 32'h90, "R13");
        rd_chk(5'h14, 32'h02, "R13");

        // R11: self-clearing soft reset
        wr(5'h04, 32'h9C);
        wr(5'h18, 32'h1);
        rd_chk(5'h18, 32'h1, "R11");
        chk(ce_n == 4'hF && !io_oe, "R11", "pins during reset", {ce_n, io_oe}, 5'h1E);
        repeat (RSTC + 2) @(negedge clk);
        rd_chk(5'h18, 32'h0, "R11");
        rd_chk(5'h04, 32'h0, "R11");
        rd_chk(5'h14, 32'h0, "R11");
        chk(io_out == 8'h00, "R11", "data cleared", io_out, 0);
        wr(5'h04, 32'h00);
        chk(io_oe == 1'b0, "R12", "io_oe off", io_oe, 0);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule